// File: doc/BRIEF.md
# Reset Sequencing Controller

This block turns four reset causes into one sequenced processor reset. It is clocked by a slow 32 kHz tick. The causes are a coarse power-on detector, a precise power-on detector, an active-high external reset pin and a watchdog expiry pulse. Power and pin causes are the hard causes. A hard cause forces the processor reset and the main-oscillator power-down control on at once, with no clock edge needed. When the last hard cause goes away, the release passes through a two-flop synchronizer. It then runs a long sequence: one reset cycle, a low-power hold-off with the oscillator still off, and one cycle with the oscillator running. Only after that is the processor reset released.

A watchdog expiry is acted on only after software has enabled the watchdog. Software enables it by writing a zero to the enable-control bit, and no later write can turn it off. Only a hard cause turns it off. The watchdog path is short: two reset cycles, with the oscillator kept running. The block also drives a clear for the bandgap trim register, which only the coarse detector asserts. It keeps a three-bit record of the latest reset cause.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Any of `por_coarse_i`, `por_fine_i` or `xres_i` at 1 drives `cpu_rst_o` and `osc_pd_o` to 1 immediately, with no clock edge. Both outputs stay at 1 while the cause is present.
- R2: `bg_trim_clr_o` rises immediately with `por_coarse_i` and falls two clock edges after it drops. `por_fine_i` alone never asserts it.
- R3: Count from the falling edge of the last hard cause. `osc_pd_o` falls after the 2052nd rising clock edge and `cpu_rst_o` falls after the 2053rd. The count is made of 2 synchronizer edges, 1 step edge, 1 reset cycle, 2048 hold-off cycles and 1 oscillator-on cycle.
- R4: The watchdog must be enabled and `cpu_rst_o` must be 0. A 1 on `wdt_expire_i` sampled at a clock edge then sets `cpu_rst_o` to 1 for exactly two cycles starting after that edge. `osc_pd_o` stays 0 throughout.
- R5: A `wdt_expire_i` pulse while `wdt_lock_o` is 0 has no effect on `cpu_rst_o`.
- R6: A clock edge with `ctl_wr_i`=1 and `ctl_wdt_off_i`=0 sets `wdt_lock_o`. A write with `ctl_wdt_off_i`=1 never clears it.
- R7: A watchdog reset leaves `wdt_lock_o` set. A hard cause clears it immediately.
- R8: A hard cause arriving during a watchdog sequence or during the hold-off aborts it. The full long sequence then restarts, with R3 timing measured from the new release.
- R9: `rst_cause_o` uses bit 2 for power-on, bit 1 for the pin and bit 0 for the watchdog. A power-on cause forces the value 3'b100. A pin cause sets bit 1 and clears bit 0, and leaves bit 2 as it was. A watchdog reset sets bit 0 and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow 32 kHz sequencing clock |
| por_coarse_i | input | 1 | Coarse power-on detector flag, asynchronous, active high |
| por_fine_i | input | 1 | Precise power-on detector flag, asynchronous, active high |
| xres_i | input | 1 | External reset pin, asynchronous, active high |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous to clk |
| ctl_wr_i | input | 1 | Software write strobe for the enable-control bit |
| ctl_wdt_off_i | input | 1 | Written value of the enable-control bit (0 enables the watchdog) |
| cpu_rst_o | output | 1 | Processor reset, active high |
| osc_pd_o | output | 1 | Main-oscillator power-down, active high |
| wdt_lock_o | output | 1 | Watchdog reset enabled and locked |
| bg_trim_clr_o | output | 1 | Clear for the bandgap trim register |
| rst_cause_o | output | 3 | Latest reset cause {power-on, pin, watchdog} |

## Verification
Two functions can fall in the same cycle: a hard cause arriving and a watchdog sequence or hold-off count that is still running. The bench provokes this by raising a power flag while `cpu_rst_o` is high from a watchdog pulse. It also raises a second hard cause about a thousand cycles into the hold-off. The hard cause passes if `osc_pd_o` goes high at once and the release count measured from the new release is again exactly 2052/2053 edges. The cause record and the lock are then read back at the ports.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    S_HOLD   = 3'd0,
    S_PULSE  = 3'd1,
    S_LOWPWR = 3'd2,
    S_WARM   = 3'd3,
    S_RUN    = 3'd4,
    S_WDR    = 3'd5,
    S_WREL   = 3'd6
  } seq_st_e;

  localparam int CAUSE_W   = 3;
  localparam int CAUSE_POR = 2;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_WDR = 0;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic sync_o
);
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] q;

  // asserts at once, releases after SW edges
  always_ff @(posedge clk or posedge async_i) begin
    if (async_i) q <= '1;
    else         q <= {q[SW-2:0], 1'b0};
  end

  assign sync_o = q[SW-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int LP_CYCLES = 2048
) (
  input  logic clk,
  input  logic hard_rst,
  input  logic wdt_req,
  output logic wdr_ack_o,
  output logic cpu_rst_o,
  output logic osc_pd_o
);
  localparam int CW = (LP_CYCLES > 1) ? $clog2(LP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LP_CYCLES - 1);

  seq_st_e       st, nx;
  logic [CW-1:0] cnt;

  assign wdr_ack_o = wdt_req && (st == S_RUN);

  always_comb begin
    nx = st;
    unique case (st)
      S_HOLD:   nx = S_PULSE;
      S_PULSE:  nx = S_LOWPWR;
      S_LOWPWR: if (cnt == LAST) nx = S_WARM;
      S_WARM:   nx = S_RUN;
      S_RUN:    if (wdt_req) nx = S_WDR;
      S_WDR:    nx = S_WREL;
      S_WREL:   nx = S_RUN;
      default:  nx = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst) begin
      st        <= S_HOLD;
      cnt       <= '0;
      cpu_rst_o <= 1'b1;
      osc_pd_o  <= 1'b1;
    end else begin
      st        <= nx;
      cnt       <= (st == S_LOWPWR) ? cnt + CW'(1) : '0;
      cpu_rst_o <= (nx != S_RUN);
      osc_pd_o  <= (nx == S_HOLD) || (nx == S_PULSE) || (nx == S_LOWPWR);
    end
  end

  // R4: watchdog start keeps oscillator running
  p_wdr_osc_on_r4: assert property (@(posedge clk) disable iff (hard_rst)
    (wdt_req && !cpu_rst_o) |=> (cpu_rst_o && !osc_pd_o));

  // R4: short path lasts exactly two cycles
  p_wdr_two_cyc_r4: assert property (@(posedge clk) disable iff (hard_rst)
    ($rose(cpu_rst_o) && !osc_pd_o) |=> cpu_rst_o ##1 !cpu_rst_o);

  // R5: no reset from running without an enabled request
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (hard_rst)
    (!cpu_rst_o && !wdt_req) |=> !cpu_rst_o);

  // R3: oscillator powers up one cycle before release
  p_osc_first_r3: assert property (@(posedge clk) disable iff (hard_rst)
    $fell(osc_pd_o) |-> cpu_rst_o ##1 !cpu_rst_o);
endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log
  import rst_seq_pkg::*;
(
  input  logic               clk,
  input  logic               por_s,
  input  logic               pin_s,
  input  logic               wdr_ack,
  input  logic               ctl_wr,
  input  logic               ctl_wdt_off,
  output logic               wdt_lock_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic hard_rst;
  assign hard_rst = por_s | pin_s;

  always_ff @(posedge clk or posedge por_s) begin
    if (por_s) begin
      cause_o <= '0;
      cause_o[CAUSE_POR] <= 1'b1;
    end else if (pin_s) begin
      cause_o[CAUSE_PIN] <= 1'b1;
      cause_o[CAUSE_WDR] <= 1'b0;
    end else if (wdr_ack) begin
      cause_o[CAUSE_WDR] <= 1'b1;
    end
  end

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst)                  wdt_lock_o <= 1'b0;
    else if (ctl_wr && !ctl_wdt_off) wdt_lock_o <= 1'b1;
  end

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (hard_rst)
    wdt_lock_o |=> wdt_lock_o);

  p_wdr_flag_r9: assert property (@(posedge clk) disable iff (hard_rst)
    wdr_ack |=> (cause_o[CAUSE_WDR] && $stable(cause_o[CAUSE_POR])));

  p_pin_flag_r9: assert property (@(posedge clk) disable iff (por_s)
    pin_s |=> (cause_o[CAUSE_PIN] && !cause_o[CAUSE_WDR]));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LP_CYCLES   = 2048
) (
  input  logic               clk,
  input  logic               por_coarse_i,
  input  logic               por_fine_i,
  input  logic               xres_i,
  input  logic               wdt_expire_i,
  input  logic               ctl_wr_i,
  input  logic               ctl_wdt_off_i,
  output logic               cpu_rst_o,
  output logic               osc_pd_o,
  output logic               wdt_lock_o,
  output logic               bg_trim_clr_o,
  output logic [CAUSE_W-1:0] rst_cause_o
);
  logic por_raw, por_s, pin_s, coarse_s, hard_s, wdr_ack;

  assign por_raw = por_coarse_i | por_fine_i;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk(clk), .async_i(por_raw), .sync_o(por_s));
  rst_sync #(.STAGES(SYNC_STAGES)) u_sync_pin (
    .clk(clk), .async_i(xres_i), .sync_o(pin_s));
  rst_sync #(.STAGES(SYNC_STAGES)) u_sync_trim (
    .clk(clk), .async_i(por_coarse_i), .sync_o(coarse_s));

  assign hard_s        = por_s | pin_s;
  assign bg_trim_clr_o = coarse_s;

  rst_seq_fsm #(.LP_CYCLES(LP_CYCLES)) u_fsm (
    .clk       (clk),
    .hard_rst  (hard_s),
    .wdt_req   (wdt_expire_i && wdt_lock_o),
    .wdr_ack_o (wdr_ack),
    .cpu_rst_o (cpu_rst_o),
    .osc_pd_o  (osc_pd_o)
  );

  rst_cause_log u_log (
    .clk         (clk),
    .por_s       (por_s),
    .pin_s       (pin_s),
    .wdr_ack     (wdr_ack),
    .ctl_wr      (ctl_wr_i),
    .ctl_wdt_off (ctl_wdt_off_i),
    .wdt_lock_o  (wdt_lock_o),
    .cause_o     (rst_cause_o)
  );

  // R1: hard cause present means processor held and oscillator off
  p_hard_hold_r1: assert property (@(posedge clk)
    (por_coarse_i || por_fine_i || xres_i) |-> (cpu_rst_o && osc_pd_o));

  // R2: precise detector alone never clears trim
  p_trim_fine_r2: assert property (@(posedge clk)
    (por_fine_i && !por_coarse_i && !bg_trim_clr_o) |=> (!por_coarse_i -> !bg_trim_clr_o));
endmodule

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic por_coarse, por_fine, xres, wdt_exp, ctl_wr, ctl_off;
  logic cpu_rst, osc_pd, wdt_lock, trim_clr;
  logic [2:0] cause;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_seq_ctrl dut (
    .clk(clk), .por_coarse_i(por_coarse), .por_fine_i(por_fine), .xres_i(xres),
    .wdt_expire_i(wdt_exp), .ctl_wr_i(ctl_wr), .ctl_wdt_off_i(ctl_off),
    .cpu_rst_o(cpu_rst), .osc_pd_o(osc_pd), .wdt_lock_o(wdt_lock),
    .bg_trim_clr_o(trim_clr), .rst_cause_o(cause));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts edges after a release; R3 expects 2052 / 2053
  task automatic measure_release(input string req);
    int n = 0;
    int osc_n = 0;
    while (n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!osc_pd && osc_n == 0) osc_n = n;
      if (!cpu_rst) break;
    end
    chk({req, " osc_pd fall edge"}, osc_n, 2052);
    chk({req, " cpu_rst fall edge"}, n, 2053);
  endtask

  task automatic t_reset_state;
    chk("R1 cpu_rst at power-on", cpu_rst, 1);
    chk("R1 osc_pd at power-on", osc_pd, 1);
    chk("R7 lock at power-on", wdt_lock, 0);
    chk("R2 trim clear with coarse", trim_clr, 1);
    chk("R9 cause after power-on", cause, 3'b100);
    por_coarse = 1'b0;
    measure_release("R3 first release");
    chk("R2 trim clear released", trim_clr, 0);
  endtask

  task automatic t_trim;
    por_fine = 1'b1; #1;
    chk("R1 fine flag async cpu_rst", cpu_rst, 1);
    chk("R1 fine flag async osc_pd", osc_pd, 1);
    cycles(3);
    chk("R2 fine alone no trim", trim_clr, 0);
    por_coarse = 1'b1; #1;
    chk("R2 coarse trim async", trim_clr, 1);
    cycles(2);
    por_coarse = 1'b0; por_fine = 1'b0;
    measure_release("R3 release after both flags");
  endtask

  task automatic t_wdr_disabled;
    wdt_exp = 1'b1; cycles(1); wdt_exp = 1'b0;
    chk("R5 expiry ignored cyc1", cpu_rst, 0);
    cycles(2);
    chk("R5 expiry ignored cyc3", cpu_rst, 0);
  endtask

  task automatic t_lock;
    ctl_wr = 1'b1; ctl_off = 1'b1; cycles(1); ctl_wr = 1'b0;
    chk("R6 writing one no enable", wdt_lock, 0);
    ctl_wr = 1'b1; ctl_off = 1'b0; cycles(1); ctl_wr = 1'b0;
    chk("R6 writing zero enables", wdt_lock, 1);
    ctl_wr = 1'b1; ctl_off = 1'b1; cycles(1); ctl_wr = 1'b0;
    chk("R6 cannot disable", wdt_lock, 1);
  endtask

  task automatic t_wdr;
    wdt_exp = 1'b1; cycles(1); wdt_exp = 1'b0;
    chk("R4 cpu_rst cyc1", cpu_rst, 1);
    chk("R4 osc_pd cyc1", osc_pd, 0);
    cycles(1);
    chk("R4 cpu_rst cyc2", cpu_rst, 1);
    chk("R4 osc_pd cyc2", osc_pd, 0);
    cycles(1);
    chk("R4 cpu_rst released", cpu_rst, 0);
    chk("R7 lock kept after watchdog", wdt_lock, 1);
    chk("R9 cause after watchdog", cause, 3'b101);
  endtask

  task automatic t_pin;
    xres = 1'b1; #1;
    chk("R1 pin async cpu_rst", cpu_rst, 1);
    chk("R7 pin clears lock", wdt_lock, 0);
    cycles(3);
    chk("R9 cause after pin", cause, 3'b110);
    xres = 1'b0;
    measure_release("R3 pin release");
  endtask

  task automatic t_abort_wdr;
    ctl_wr = 1'b1; ctl_off = 1'b0; cycles(1); ctl_wr = 1'b0;
    wdt_exp = 1'b1; cycles(1); wdt_exp = 1'b0;
    chk("R4 watchdog started", cpu_rst, 1);
    por_fine = 1'b1; #1;
    chk("R8 abort forces osc_pd", osc_pd, 1);
    cycles(2);
    por_fine = 1'b0;
    measure_release("R8 restart after watchdog abort");
    chk("R9 cause after abort", cause, 3'b100);
  endtask

  task automatic t_abort_lp;
    xres = 1'b1; cycles(2); xres = 1'b0;
    cycles(1000);
    chk("R8 mid hold-off osc_pd", osc_pd, 1);
    por_coarse = 1'b1; cycles(1); por_coarse = 1'b0;
    measure_release("R8 restart mid hold-off");
  endtask

  initial begin
    por_coarse = 1'b1; por_fine = 1'b0; xres = 1'b0;
    wdt_exp = 1'b0; ctl_wr = 1'b0; ctl_off = 1'b1;
    cycles(4);
    t_reset_state();
    t_trim();
    t_wdr_disabled();
    t_lock();
    t_wdr();
    t_pin();
    t_abort_wdr();
    t_abort_lp();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule